// File: doc/BRIEF.md
# Blocking Write-Through Cache Controller

This block sits between a processor port and a request/response memory port. It keeps a direct-mapped store of lines, each line holding several words, and it tells the processor in the same cycle whether a request was taken. A request that is not taken must be offered again by the processor. Load data comes back on a response port that the processor samples every cycle. A valid response lasts one cycle and is never held back.

Every store goes to memory in the cycle it is accepted. The cached copy therefore never differs from memory, and the block needs no dirty state and no eviction path. A store that hits also updates the cached word. A store that misses leaves the store unchanged. A load miss sends one line read to memory. After that, the controller refuses all requests until memory returns the line. The returned line is written into the store, and the word that was asked for is returned to the processor.

Addresses count words. Each address is split, from the most significant bit down, into a tag, a line index and a word offset.

Top module: `wtCache`

## Requirements
- R1: After reset every line is invalid, so the first load to any address is treated as a miss.
- R2: While a miss is outstanding, `reqAccepted` is 0 for every request and no memory request is issued. A miss is outstanding from the clock edge that accepts the load miss until the clock edge at which its line is taken.
- R3: A load that misses is accepted only in a cycle where `memReqReady` is 1. In that same cycle the block drives `memReqValid`=1 and `memReqWrite`=0, and `memReqAddr` equals the request address with its word-offset bits set to zero.
- R4: When `memRespValid` is 1 while a miss is outstanding, `memRespReady` is 1 in the same cycle and the line is written into the store. In the next cycle `respValid` is 1 and `respData` holds the missed word. In `memRespLine`, word w occupies bits [w*WORD_W +: WORD_W].
- R5: A load that hits is accepted whatever the value of `memReqReady`, issues no memory request, and gives `respValid`=1 with the stored word in the next cycle.
- R6: A store is accepted only when `memReqReady` is 1. In the same cycle the block drives `memReqValid`=1 and `memReqWrite`=1, with `memReqAddr`=`reqAddr` and `memReqData`=`reqData`. A store produces no response.
- R7: A store hit replaces the cached word, so later loads return the new value. A store miss does not allocate a line: a later load to that address misses and returns the value taken from memory.
- R8: `respValid` is 1 only in the cycle after an accepted load hit or after a fill. A rejected request produces no response.
- R9: Once a line has been filled, loads to any word of that line hit. This lasts until a line with a different tag is filled at the same index.
- R10: `memRespValid` with no miss outstanding is ignored: `memRespReady` stays 0, no response appears, and the cache contents do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor offers a request this cycle |
| reqWrite | input | 1 | 1 = store, 0 = load |
| reqAddr | input | ADDR_W | Word address {tag, index, offset} |
| reqData | input | WORD_W | Store data |
| reqAccepted | output | 1 | Request taken this cycle (combinational) |
| respValid | output | 1 | Load data valid this cycle |
| respData | output | WORD_W | Load data |
| memReqValid | output | 1 | Memory request issued this cycle |
| memReqWrite | output | 1 | 1 = store word, 0 = line read |
| memReqAddr | output | ADDR_W | Word address of a store, or line base of a read |
| memReqData | output | WORD_W | Store data sent to memory |
| memReqReady | input | 1 | Memory request queue has room |
| memRespValid | input | 1 | Memory presents a line |
| memRespLine | input | WORD_W*LINE_WORDS | Returned line, word w at bits w*WORD_W |
| memRespReady | output | 1 | Line taken this cycle |

## Verification
The bench builds the block with a 10-bit address, 32-bit words, four words per line and only four lines. Drawing tags from a small pool then produces frequent conflict refills at the same index, as well as store hits, store misses and hits that follow fills, all within a few hundred operations. A fixed-latency memory model holds a shadow copy of memory, which checks that each read returns the latest written value. While a miss is pending, the bench keeps offering requests to confirm that the controller blocks. It also drops `memReqReady` at random, which separates hits (accepted anyway) from misses and stores (refused).

// File: rtl/wtCachePkg.sv
package wtCachePkg;
  typedef struct packed {
    logic loadHitResp;
    logic storeHit;
    logic captureMiss;
    logic fill;
  } cacheStrobes_t;
endpackage

// File: rtl/wtCacheCtrl.sv
module wtCacheCtrl
  import wtCachePkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic          reqWrite,
  input  logic          hit,
  input  logic          memReqReady,
  input  logic          memRespValid,
  output logic          reqAccepted,
  output logic          memReqValid,
  output logic          memReqWrite,
  output logic          memRespReady,
  output logic          missPending,
  output cacheStrobes_t strobes
);
  typedef enum logic {IDLE, WAIT_FILL} ctrlState_t;
  ctrlState_t state;

  logic accept;
  logic fillNow;

  assign missPending = (state == WAIT_FILL);
  assign accept = reqValid && !missPending &&
                  (reqWrite ? memReqReady : (hit || memReqReady));
  assign fillNow = missPending && memRespValid;

  always_comb begin
    strobes.loadHitResp = accept && !reqWrite && hit;
    strobes.captureMiss = accept && !reqWrite && !hit;
    strobes.storeHit    = accept && reqWrite && hit;
    strobes.fill        = fillNow;
  end

  assign reqAccepted  = accept;
  assign memReqWrite  = accept && reqWrite;
  assign memReqValid  = strobes.captureMiss || memReqWrite;
  assign memRespReady = fillNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= IDLE;
    end else begin
      case (state)
        IDLE:      if (strobes.captureMiss) state <= WAIT_FILL;
        WAIT_FILL: if (fillNow) state <= IDLE;
        default:   state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtCacheDatapath.sv
module wtCacheDatapath
  import wtCachePkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  localparam int OFF_W  = $clog2(LINE_WORDS),
  localparam int IDX_W  = $clog2(NUM_LINES),
  localparam int TAG_W  = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic                clk,
  input  logic                rstN,
  input  cacheStrobes_t       strobes,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [WORD_W-1:0]   reqData,
  input  logic [LINE_W-1:0]   memRespLine,
  output logic                hit,
  output logic                respValid,
  output logic [WORD_W-1:0]   respData,
  output logic [ADDR_W-1:0]   memReqAddr,
  output logic [WORD_W-1:0]   memReqData
);
  logic [TAG_W-1:0]  tagArr  [NUM_LINES];
  logic [WORD_W-1:0] dataArr [NUM_LINES][LINE_WORDS];
  logic [NUM_LINES-1:0] validBits;
  logic [ADDR_W-1:0] missAddr;
  logic [WORD_W-1:0] fillWords [LINE_WORDS];

  logic [IDX_W-1:0] reqIdx, missIdx;
  logic [OFF_W-1:0] reqOff, missOff;
  logic [TAG_W-1:0] reqTag, missTag;

  assign reqIdx  = reqAddr[OFF_W +: IDX_W];
  assign reqOff  = reqAddr[OFF_W-1:0];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign missIdx = missAddr[OFF_W +: IDX_W];
  assign missOff = missAddr[OFF_W-1:0];
  assign missTag = missAddr[ADDR_W-1 -: TAG_W];

  for (genvar w = 0; w < LINE_WORDS; w++) begin : g_split
    assign fillWords[w] = memRespLine[w*WORD_W +: WORD_W];
  end

  assign hit = validBits[reqIdx] && (tagArr[reqIdx] == reqTag);

  assign memReqAddr = reqWrite ? reqAddr : {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memReqData = reqData;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validBits <= '0;
    end else if (strobes.fill) begin
      validBits[missIdx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.captureMiss) missAddr <= reqAddr;
    if (strobes.fill) begin
      tagArr[missIdx] <= missTag;
      for (int w = 0; w < LINE_WORDS; w++) dataArr[missIdx][w] <= fillWords[w];
    end else if (strobes.storeHit) begin
      dataArr[reqIdx][reqOff] <= reqData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      respValid <= 1'b0;
      respData  <= '0;
    end else begin
      respValid <= strobes.loadHitResp || strobes.fill;
      if (strobes.fill)             respData <= fillWords[missOff];
      else if (strobes.loadHitResp) respData <= dataArr[reqIdx][reqOff];
    end
  end
endmodule

// File: rtl/wtCache.sv
module wtCache
  import wtCachePkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int NUM_LINES  = 16,
  localparam int LINE_W = WORD_W * LINE_WORDS
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [WORD_W-1:0] reqData,
  output logic              reqAccepted,
  output logic              respValid,
  output logic [WORD_W-1:0] respData,
  output logic              memReqValid,
  output logic              memReqWrite,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [WORD_W-1:0] memReqData,
  input  logic              memReqReady,
  input  logic              memRespValid,
  input  logic [LINE_W-1:0] memRespLine,
  output logic              memRespReady
);
  cacheStrobes_t strobes;
  logic hit;
  logic missPending;

  wtCacheCtrl u_ctrl (
    .clk, .rstN, .reqValid, .reqWrite, .hit, .memReqReady, .memRespValid,
    .reqAccepted, .memReqValid, .memReqWrite, .memRespReady, .missPending,
    .strobes
  );

  wtCacheDatapath #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS), .NUM_LINES(NUM_LINES)
  ) u_dp (
    .clk, .rstN, .strobes, .reqWrite, .reqAddr, .reqData, .memRespLine,
    .hit, .respValid, .respData, .memReqAddr, .memReqData
  );
endmodule

// File: rtl/wtCacheChecker.sv
module wtCacheChecker #(
  parameter int ADDR_W     = 16,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  localparam int OFF_W = $clog2(LINE_WORDS)
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [WORD_W-1:0] reqData,
  input logic              reqAccepted,
  input logic              respValid,
  input logic              memReqValid,
  input logic              memReqWrite,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic [WORD_W-1:0] memReqData,
  input logic              memReqReady,
  input logic              memRespValid,
  input logic              memRespReady,
  input logic              missPending
);
  assert_block_R2: assert property (@(posedge clk) disable iff (!rstN)
    missPending |-> (!reqAccepted && !memReqValid));

  assert_miss_issue_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccepted && !reqWrite && memReqValid) |->
      (!memReqWrite && memReqAddr[OFF_W-1:0] == '0 &&
       memReqAddr[ADDR_W-1:OFF_W] == reqAddr[ADDR_W-1:OFF_W]) ##1 missPending);

  assert_req_ready_R3: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |-> memReqReady);

  assert_fill_resp_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRespValid && memRespReady) |=> (respValid && !missPending));

  assert_store_through_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqAccepted && reqWrite) |->
      (memReqValid && memReqWrite && memReqAddr == reqAddr && memReqData == reqData));

  assert_resp_source_R8: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> ($past(reqValid && reqAccepted && !reqWrite && !memReqValid) ||
                   $past(memRespValid && memRespReady)));

  assert_ignore_resp_R10: assert property (@(posedge clk) disable iff (!rstN)
    memRespReady |-> missPending);
endmodule

bind wtCache wtCacheChecker #(
  .ADDR_W(ADDR_W), .WORD_W(WORD_W), .LINE_WORDS(LINE_WORDS)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
  .reqAddr(reqAddr), .reqData(reqData), .reqAccepted(reqAccepted),
  .respValid(respValid), .memReqValid(memReqValid), .memReqWrite(memReqWrite),
  .memReqAddr(memReqAddr), .memReqData(memReqData), .memReqReady(memReqReady),
  .memRespValid(memRespValid), .memRespReady(memRespReady),
  .missPending(missPending)
);

// File: tb/wtCache_tb.sv
module wtCache_tb;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 32;
  localparam int LW = 4;
  localparam int NL = 4;
  localparam int LAT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic reqAccepted, respValid, memReqValid, memReqWrite, memRespReady;
  logic [DW-1:0] respData, memReqData;
  logic [AW-1:0] memReqAddr;
  logic memReqReady = 1'b1, memRespValid = 1'b0;
  logic [DW*LW-1:0] memRespLine = '0;

  int checks = 0;
  int errors = 0;

  logic [DW-1:0] shadow [1 << AW];
  logic          mValid [NL];
  logic [5:0]    mTag   [NL];

  always #(CLK_PERIOD/2) clk = ~clk;

  wtCache #(.ADDR_W(AW), .WORD_W(DW), .LINE_WORDS(LW), .NUM_LINES(NL)) u_dut (
    .clk, .rstN, .reqValid, .reqWrite, .reqAddr, .reqData, .reqAccepted,
    .respValid, .respData, .memReqValid, .memReqWrite, .memReqAddr, .memReqData,
    .memReqReady, .memRespValid, .memRespLine, .memRespReady
  );

  function automatic logic [1:0] idxOf(input logic [AW-1:0] a);
    return a[3:2];
  endfunction
  function automatic logic [5:0] tagOf(input logic [AW-1:0] a);
    return a[9:4];
  endfunction
  function automatic logic expHit(input logic [AW-1:0] a);
    return mValid[idxOf(a)] && (mTag[idxOf(a)] == tagOf(a));
  endfunction
  function automatic logic [DW*LW-1:0] lineOf(input logic [AW-1:0] a);
    logic [DW*LW-1:0] l;
    for (int w = 0; w < LW; w++) l[w*DW +: DW] = shadow[{a[9:2], w[1:0]}];
    return l;
  endfunction

  task automatic check(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", what, act, exp);
    end
  endtask

  task automatic doOp(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d, input logic readyFirst);
    logic isHit, acc, rdy, expAcc;
    int tries = 0;
    string tagStr;
    isHit = expHit(a);
    tagStr = wr ? "R6 store" : (isHit ? "R5 R9 load hit" : "R1 R3 load miss");
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk);
      if (tries > 0) begin
        #1;
        check(respValid == 1'b0, "R8 no resp after reject", 64'(respValid), 64'd0);
      end
      rdy = (tries == 0) ? readyFirst : 1'b1;
      reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqData = d; memReqReady = rdy;
      #1;
      expAcc = wr ? rdy : (isHit || rdy);
      acc = reqAccepted;
      check(reqAccepted == expAcc, tagStr, 64'(reqAccepted), 64'(expAcc));
      if (reqAccepted && (wr || !isHit)) begin
        check(memReqValid && memReqWrite == wr, {tagStr, " mem req"}, 64'({memReqValid, memReqWrite}), 64'({1'b1, wr}));
        check(memReqAddr == (wr ? a : {a[9:2], 2'b00}), {tagStr, " mem addr"}, 64'(memReqAddr), 64'(wr ? a : {a[9:2], 2'b00}));
        if (wr) check(memReqData == d, "R6 mem data", 64'(memReqData), 64'(d));
      end else begin
        check(memReqValid == 1'b0, {tagStr, " no mem req"}, 64'(memReqValid), 64'd0);
      end
      tries++;
      @(posedge clk);
    end
    if (wr) shadow[a] = d;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    if (wr) begin
      check(respValid == 1'b0, "R6 store gives no resp", 64'(respValid), 64'd0);
    end else if (isHit) begin
      check(respValid && respData == shadow[a], "R5 R7 hit data", 64'(respData), 64'(shadow[a]));
    end else begin
      check(respValid == 1'b0, "R8 no resp at miss issue", 64'(respValid), 64'd0);
      for (int c = 0; c < LAT; c++) begin
        if (c > 0) @(negedge clk);
        reqValid = 1'b1; reqWrite = 1'($urandom % 2);
        reqAddr = AW'($urandom); reqData = $urandom; memReqReady = 1'b1;
        #1;
        check(!reqAccepted && !memReqValid && !respValid && !memRespReady,
              "R2 blocked while pending", 64'({reqAccepted, memReqValid, respValid, memRespReady}), 64'd0);
      end
      @(negedge clk);
      reqValid = 1'b0; memRespValid = 1'b1; memRespLine = lineOf(a);
      #1;
      check(memRespReady == 1'b1, "R4 fill taken", 64'(memRespReady), 64'd1);
      @(negedge clk);
      memRespValid = 1'b0;
      #1;
      check(respValid && respData == shadow[a], "R4 R7 fill word", 64'(respData), 64'(shadow[a]));
      mValid[idxOf(a)] = 1'b1;
      mTag[idxOf(a)] = tagOf(a);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog R2: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd4242));
    for (int i = 0; i < (1 << AW); i++) shadow[i] = (32'(i) * 32'h0100_0193) ^ 32'hA5A5_0000;
    for (int i = 0; i < NL; i++) begin mValid[i] = 1'b0; mTag[i] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(respValid == 1'b0 && memReqValid == 1'b0 && memRespReady == 1'b0,
          "R1 reset outputs idle", 64'({respValid, memReqValid, memRespReady}), 64'd0);

    // R10: stray memory response with nothing pending
    @(negedge clk);
    memRespValid = 1'b1; memRespLine = '1;
    #1;
    check(memRespReady == 1'b0, "R10 stray resp not taken", 64'(memRespReady), 64'd0);
    @(negedge clk);
    memRespValid = 1'b0;
    #1;
    check(respValid == 1'b0, "R10 stray resp no output", 64'(respValid), 64'd0);

    // R1/R3: first load misses, refused without memReqReady
    doOp(1'b0, 10'h005, '0, 1'b0);
    // R5/R9: another word of the same line hits even with memReqReady low
    doOp(1'b0, 10'h006, '0, 1'b0);
    // R6/R7: store hit refused first, then written through and visible
    doOp(1'b1, 10'h006, 32'hDEAD_BEEF, 1'b0);
    doOp(1'b0, 10'h006, '0, 1'b0);
    // R7: store miss does not allocate
    doOp(1'b1, 10'h105, 32'h1234_5678, 1'b1);
    doOp(1'b0, 10'h105, '0, 1'b1);
    // R9: conflict refill evicts earlier line at same index
    doOp(1'b0, 10'h007, '0, 1'b0);

    for (int n = 0; n < 400; n++) begin
      a = {4'b0, 2'($urandom % 4), 2'($urandom), 2'($urandom)};
      doOp(1'($urandom % 3 == 0), a, $urandom, 1'($urandom % 4 != 0));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule